// File: doc/BRIEF.md
# Periodic Battery Health Tester

This block decides when a backup battery is put under load and whether the battery has failed. It counts pulses of a slow timebase. While main power is good it switches a load resistor onto the battery for a short window at a fixed interval. A digitised comparator flag tells the block whether the battery voltage dropped below its trip level during that window. The analog load and the comparator sit outside the block.

The warning output is active low and is meant to drive an open-drain pad. Once a failing periodic test sets it, it stays set. Every time main power returns, a fresh test runs. If that power-up test passes, the warning is released and the interval schedule starts again. A module-replaced input also releases the warning.

The interval and the window are parameters counted in timebase ticks. With the defaults and a one-second tick they give one day and one second.

Top module: `batt_health_tester`

## Requirements
- R1: During and after reset, `load_en` is 0 and `warn_n` is 1. On `warn_n`, 0 means warning asserted and 1 means released (high impedance on the pad).
- R2: When `pwr_ok` is sampled high after being low or after reset, `load_en` goes to 1 on that same clock edge, even if the warning is already set. It stays at 1 through WINDOW_TICKS timebase ticks and returns to 0 on the edge that samples the last of those ticks.
- R3: After a test ends, the next test starts on the edge that samples the INTERVAL_TICKS-th tick counted from the end of that test, provided power stays good.
- R4: If `batt_low` is sampled high in any cycle of a test window, including the cycle of its final tick, `warn_n` goes to 0 on the edge that ends the window and not earlier.
- R5: A passing periodic test leaves an asserted warning asserted.
- R6: A passing power-up test releases the warning (`warn_n` returns to 1 when its window ends).
- R7: `replaced` sampled high sets `warn_n` to 1 on that edge. It takes priority over a failing test result that ends in the same cycle.
- R8: `pwr_ok` sampled low clears `load_en` on that edge. While power is low, timebase ticks start no test, and the warning holds its value.
- R9: A test cut short by a power failure does not change the warning, even if `batt_low` was seen during it.
- R10: The interval count restarts on every power failure. After power returns, the first periodic test comes a full INTERVAL_TICKS ticks after the power-up test ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase pulse, one clock wide |
| pwr_ok | input | 1 | Main supply in tolerance and recovery delay elapsed |
| replaced | input | 1 | Module-replaced indication; releases the warning |
| batt_low | input | 1 | Battery below trip level (comparator result) |
| load_en | output | 1 | Connects the test load to the battery |
| warn_n | output | 1 | Battery warning, active low, open-drain style |

## Verification
The bench builds the block with INTERVAL_TICKS = 5 and WINDOW_TICKS = 3. These values make every tick of an interval and every cycle position of a comparator hit inside the window cheap to sweep one by one. They also bring within a few hundred cycles the sequences that cross power cycles: warning set, power lost, retested and cleared on power-up, and an interval restarted after a partial count.

// File: rtl/bht_pkg.sv
package bht_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_TEST = 2'd1,
    ST_WAIT = 2'd2
  } bht_state_t;
endpackage

// File: rtl/bht_tick_counter.sv
// Counts enabled ticks modulo LIMIT; done marks the tick that wraps.
module bht_tick_counter #(
  parameter int unsigned LIMIT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic done
);
  localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  assign done = en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (en)    cnt <= done ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/bht_warn_latch.sv
// Sticky warning flag: replaced > failing result > passing power-up result.
module bht_warn_latch (
  input  logic clk,
  input  logic rst,
  input  logic replaced,
  input  logic fail_set,
  input  logic pass_clr,
  output logic warn_n
);
  always_ff @(posedge clk) begin
    if (rst)           warn_n <= 1'b1;
    else if (replaced) warn_n <= 1'b1;
    else if (fail_set) warn_n <= 1'b0;
    else if (pass_clr) warn_n <= 1'b1;
  end
endmodule

// File: rtl/batt_health_tester.sv
module batt_health_tester #(
  parameter int unsigned INTERVAL_TICKS = 86400,
  parameter int unsigned WINDOW_TICKS   = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic pwr_ok,
  input  logic replaced,
  input  logic batt_low,
  output logic load_en,
  output logic warn_n
);
  import bht_pkg::*;

  bht_state_t state, state_nx;
  logic fail_acc;
  logic pu_test;
  logic in_test, in_wait;
  logic win_done, ivl_done;
  logic test_end, result_fail;

  assign in_test = (state == ST_TEST);
  assign in_wait = (state == ST_WAIT);

  bht_tick_counter #(.LIMIT(WINDOW_TICKS)) u_win (
    .clk (clk),
    .rst (rst),
    .clr (!in_test),
    .en  (tick && in_test && pwr_ok),
    .done(win_done)
  );

  bht_tick_counter #(.LIMIT(INTERVAL_TICKS)) u_ivl (
    .clk (clk),
    .rst (rst),
    .clr (!in_wait),
    .en  (tick && in_wait && pwr_ok),
    .done(ivl_done)
  );

  assign result_fail = fail_acc || batt_low;
  assign test_end    = in_test && pwr_ok && win_done;

  always_comb begin
    state_nx = state;
    if (!pwr_ok) begin
      state_nx = ST_OFF;
    end else begin
      case (state)
        ST_OFF:  state_nx = ST_TEST;
        ST_TEST: if (win_done) state_nx = ST_WAIT;
        ST_WAIT: if (ivl_done) state_nx = ST_TEST;
        default: state_nx = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_OFF;
      load_en  <= 1'b0;
      fail_acc <= 1'b0;
      pu_test  <= 1'b0;
    end else begin
      state   <= state_nx;
      load_en <= (state_nx == ST_TEST);
      if (state_nx == ST_TEST && !in_test) begin
        fail_acc <= 1'b0;
        pu_test  <= (state == ST_OFF);
      end else if (in_test) begin
        fail_acc <= result_fail;
      end
    end
  end

  bht_warn_latch u_warn (
    .clk     (clk),
    .rst     (rst),
    .replaced(replaced),
    .fail_set(test_end && result_fail),
    .pass_clr(test_end && !result_fail && pu_test),
    .warn_n  (warn_n)
  );
endmodule

// File: rtl/bht_checker.sv
module bht_checker (
  input logic clk,
  input logic rst,
  input logic pwr_ok,
  input logic replaced,
  input logic load_en,
  input logic warn_n
);
  // R8: load removed on the edge that samples power low
  a_r8_load_off_without_power: assert property (@(posedge clk) disable iff (rst)
    !pwr_ok |=> !load_en);

  // R2: the load is only applied while power was good
  a_r2_load_rise_needs_power: assert property (@(posedge clk) disable iff (rst)
    $rose(load_en) |-> $past(pwr_ok));

  // R4: warning asserts only at the close of a load window
  a_r4_warn_at_window_end: assert property (@(posedge clk) disable iff (rst)
    $fell(warn_n) |-> ($past(load_en) && !load_en));

  // R7: replacement releases the warning
  a_r7_replace_releases: assert property (@(posedge clk) disable iff (rst)
    replaced |=> warn_n);

  // R9: warning frozen while power is low and no replacement
  a_r9_warn_hold_off: assert property (@(posedge clk) disable iff (rst)
    (!pwr_ok && !replaced) |=> $stable(warn_n));
endmodule

bind batt_health_tester bht_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .pwr_ok  (pwr_ok),
  .replaced(replaced),
  .load_en (load_en),
  .warn_n  (warn_n)
);

// File: tb/batt_health_tester_test.sv
`timescale 1ns/1ps
module batt_health_tester_test;
  localparam int unsigned IVL = 5;
  localparam int unsigned WIN = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic pwr_ok = 1'b0;
  logic replaced = 1'b0;
  logic batt_low = 1'b0;
  logic load_en, warn_n;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  batt_health_tester #(.INTERVAL_TICKS(IVL), .WINDOW_TICKS(WIN)) uut (
    .clk(clk), .rst(rst), .tick(tick), .pwr_ok(pwr_ok),
    .replaced(replaced), .batt_low(batt_low),
    .load_en(load_en), .warn_n(warn_n)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic tk();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tk();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    chk("R1 load_en in reset", load_en, 1'b0);
    chk("R1 warn_n in reset", warn_n, 1'b1);
    rst = 1'b0;
    cyc();
    chk("R1 load_en after reset", load_en, 1'b0);
    chk("R1 warn_n after reset", warn_n, 1'b1);

    ticks(3);
    chk("R8 no test while off", load_en, 1'b0);

    // R2: power-up test window length
    pwr_ok = 1'b1;
    cyc();
    chk("R2 load on at power-up", load_en, 1'b1);
    ticks(WIN - 1);
    chk("R2 load held in window", load_en, 1'b1);
    tk();
    chk("R2 load off at window end", load_en, 1'b0);
    chk("R2 pass keeps warn released", warn_n, 1'b1);

    // R3: every tick of the interval
    for (int i = 1; i < IVL; i++) begin
      tk();
      chk("R3 idle inside interval", load_en, 1'b0);
    end
    tk();
    chk("R3 periodic test starts", load_en, 1'b1);

    // R4: sweep position of comparator hit in the window
    for (int p = 0; p < WIN; p++) begin
      for (int t = 0; t < WIN; t++) begin
        if (t == p) begin
          batt_low = 1'b1;
          cyc();
          batt_low = 1'b0;
        end
        tk();
        if (t < WIN - 1) chk("R4 no early warning", warn_n, 1'b1);
        else             chk("R4 warning at window end", warn_n, 1'b0);
      end
      replaced = 1'b1;
      cyc();
      replaced = 1'b0;
      chk("R7 replace releases", warn_n, 1'b1);
      ticks(IVL);
      chk("R3 next periodic test", load_en, 1'b1);
    end

    // R4: hit on the cycle of the final tick
    ticks(WIN - 1);
    tick = 1'b1; batt_low = 1'b1;
    cyc();
    tick = 1'b0; batt_low = 1'b0;
    chk("R4 hit on final tick", warn_n, 1'b0);

    // R5: passing periodic test keeps warning
    ticks(IVL);
    chk("R5 periodic test runs", load_en, 1'b1);
    ticks(WIN);
    chk("R5 warning sticky", warn_n, 1'b0);

    // R7: replace beats failing result
    ticks(IVL);
    ticks(WIN - 1);
    tick = 1'b1; batt_low = 1'b1; replaced = 1'b1;
    cyc();
    tick = 1'b0; batt_low = 1'b0; replaced = 1'b0;
    chk("R7 replace over fail", warn_n, 1'b1);

    // R9: aborted test
    ticks(IVL);
    chk("R9 test running", load_en, 1'b1);
    batt_low = 1'b1;
    cyc();
    pwr_ok = 1'b0;
    cyc();
    batt_low = 1'b0;
    chk("R8 load off on power fail", load_en, 1'b0);
    chk("R9 abort leaves warning", warn_n, 1'b1);

    // R4 on power-up test, then R6
    pwr_ok = 1'b1;
    cyc();
    batt_low = 1'b1;
    cyc();
    batt_low = 1'b0;
    ticks(WIN);
    chk("R4 power-up test fails", warn_n, 1'b0);
    pwr_ok = 1'b0;
    cyc();
    ticks(2);
    chk("R8 warning held while off", warn_n, 1'b0);
    pwr_ok = 1'b1;
    cyc();
    chk("R2 retest despite warning", load_en, 1'b1);
    ticks(WIN);
    chk("R6 power-up pass releases", warn_n, 1'b1);

    // R10: interval restarts after power failure
    ticks(2);
    pwr_ok = 1'b0;
    cyc();
    pwr_ok = 1'b1;
    cyc();
    ticks(WIN);
    chk("R10 power-up test done", load_en, 1'b0);
    ticks(IVL - 1);
    chk("R10 full interval still counting", load_en, 1'b0);
    tk();
    chk("R10 test after full interval", load_en, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule